// File: doc/BRIEF.md
# Uninitialized-Data Shadow Checker

This block runs beside an in-order 16-bit core and tracks whether data is defined. It keeps one "initialized" shadow bit for each general register. The core supplies the shadow bits for the memory words that an instruction touches: the fetched word, the loaded word, the pointer or vector word, the popped status word and the word at a new PC. For each retiring instruction the block moves these bits along the data path of that instruction. When strict checking is enabled, it reports an error code if undefined data would be consumed at a point that matters.

Each request is classified by instruction class. The block resolves the possible violations in a fixed priority order and registers the result. One cycle later it presents the error code, the PC of the faulting instruction and the memory-shadow write that the core should commit. An instruction that faults commits no shadow update. Loads and stores that use the stack register (R6) as their base, and accesses that land inside a loader-allocated address range, are exempt from the value checks. A small range table holds those ranges. It is written through a configuration port, and a range that runs past the top of the address space is split into two entries on the write.

Top module: `shdw_checker`

## Requirements
- R1: With strict_i low, err_code_o is always 0 (none). Shadow propagation continues unchanged: an ALU result built from an undefined source marks its destination undefined.
- R2: Class ALU (code 1) writes register dst_i with shadow const_res_i | (src_a shadow & (src_b_en_i ? src_b shadow : 1)). A result that is undefined raises REG_SET (code 6).
- R3: Classes LD (2) and LDI (3) write dst_i with mem_init_i. An undefined loaded word raises REG_SET (6) unless base_used_i is set with base_i = 6 or ea_i is inside an allocated range.
- R4: Classes ST (4) and STI (5) below the I/O region store the src_a shadow. An undefined value raises MEM_SET (7), with the same two exemptions as R3. A committed store drives mem_sh_we_o = 1 with mem_sh_addr_o = ea_i and mem_sh_val_o = the src_a shadow.
- R5: A store with ea_i >= 0xFE00 and an undefined src_a raises IO_SET (8) with no exemption. A store to that region never drives mem_sh_we_o.
- R6: An undefined base register on LD/ST with base_used_i set, or ptr_init_i = 0 on LDI/STI, raises MEM_ADDR (2).
- R7: JMP (7) with an undefined base register raises JMP_ADDR (3). JSRR (9) with an undefined base register, or TRAP (10) with ptr_init_i = 0, raises SR_ADDR (4). A committed JSR (8), JSRR or TRAP marks R7 defined.
- R8: A taken transfer raises PC_NEXT (9) when npc_init_i = 0. Taken transfers are BR (6) with taken_i set, JMP, JSR, JSRR, TRAP and RTI (11). A BR with taken_i low never raises PC_NEXT.
- R9: fetch_init_i = 0 raises PC_CUR (1) for any class. An RTI with psr_init_i = 0 raises PSR_SET (5).
- R10: Only one code is reported. Priority from highest to lowest: PC_CUR; then the address and target errors (2, 3, 4, 5); then the value errors (6, 7, 8); then PC_NEXT.
- R11: In the cycle after a faulting request, err_valid_o is 1 and err_pc_o equals that request's pc_i. The register shadows do not change, and mem_sh_we_o is 0.
- R12: A configuration write of (start, len) to entry i covers start <= addr < start+len. When start+len exceeds 0x10000, entry i covers [start, 0xFFFF] and entry (i+1) mod N covers [0, start+len-0x10000). When start+len equals 0x10000, the entry covers 0xFFFF. A length of 0 clears the entry.
- R13: A request in the same cycle as a configuration write is checked against the table as it was before that write.
- R14: Results appear one cycle after the request. After reset all register shadows are 0 (undefined), no error is reported and mem_sh_we_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| strict_i | input | 1 | Enable strict checking |
| cfg_we_i | input | 1 | Range table write strobe |
| cfg_idx_i | input | 2 | Range table entry index |
| cfg_start_i | input | 16 | Range start address |
| cfg_len_i | input | 17 | Range length in words |
| req_valid_i | input | 1 | Retiring instruction present |
| cls_i | input | 4 | Instruction class code |
| pc_i | input | 16 | PC of the retiring instruction |
| dst_i | input | 3 | Destination register |
| src_a_i | input | 3 | First source / store data register |
| src_b_i | input | 3 | Second source register |
| src_b_en_i | input | 1 | Second source is a register (not immediate) |
| const_res_i | input | 1 | ALU result does not depend on its sources |
| base_i | input | 3 | Base / target register |
| base_used_i | input | 1 | Load/store address is register-based |
| ea_i | input | 16 | Effective address of the data access |
| fetch_init_i | input | 1 | Fetched instruction word is defined |
| mem_init_i | input | 1 | Loaded data word is defined |
| ptr_init_i | input | 1 | Indirect pointer or trap vector word is defined |
| psr_init_i | input | 1 | Popped status word is defined |
| taken_i | input | 1 | Branch is taken |
| npc_init_i | input | 1 | Word at the new PC is defined |
| err_valid_o | output | 1 | Error reported this cycle |
| err_code_o | output | 4 | Error code, 0 for none |
| err_pc_o | output | 16 | PC of the faulting instruction |
| mem_sh_we_o | output | 1 | Memory shadow write strobe |
| mem_sh_addr_o | output | 16 | Memory shadow write address |
| mem_sh_val_o | output | 1 | Memory shadow write value |
| reg_shadow_o | output | 8 | Current register shadow bits |

## Verification
Two events can fall in the same cycle: a range table write, and a load that lands in the range being written or cleared. The bench drives both on one edge, with an undefined loaded word. It expects REG_SET when the range is being added and no error when it is being removed, because the request must see the old table. It then repeats the load alone and expects the opposite outcome. Random traffic also mixes table writes with requests, and a bench model that applies writes only after evaluating the request judges every result.

// File: rtl/shdw_pkg.sv
package shdw_pkg;
  typedef enum logic [3:0] {
    CLS_NOP  = 4'd0,
    CLS_ALU  = 4'd1,
    CLS_LD   = 4'd2,
    CLS_LDI  = 4'd3,
    CLS_ST   = 4'd4,
    CLS_STI  = 4'd5,
    CLS_BR   = 4'd6,
    CLS_JMP  = 4'd7,
    CLS_JSR  = 4'd8,
    CLS_JSRR = 4'd9,
    CLS_TRAP = 4'd10,
    CLS_RTI  = 4'd11
  } cls_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_PC_CUR   = 4'd1,
    ERR_MEM_ADDR = 4'd2,
    ERR_JMP_ADDR = 4'd3,
    ERR_SR_ADDR  = 4'd4,
    ERR_PSR_SET  = 4'd5,
    ERR_REG_SET  = 4'd6,
    ERR_MEM_SET  = 4'd7,
    ERR_IO_SET   = 4'd8,
    ERR_PC_NEXT  = 4'd9
  } err_e;
endpackage

// File: rtl/shdw_regfile.sv
module shdw_regfile #(
  parameter int unsigned N_REGS = 8,
  parameter logic [N_REGS-1:0] RESET_VAL = '0,
  localparam int unsigned REG_W = $clog2(N_REGS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [REG_W-1:0]  waddr_i,
  input  logic              wdata_i,
  output logic [N_REGS-1:0] sh_o
);
  logic [N_REGS-1:0] sh_q;

  for (genvar i = 0; i < N_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) sh_q[i] <= RESET_VAL[i];
      else if (we_i && waddr_i == REG_W'(i)) sh_q[i] <= wdata_i;
    end
  end

  assign sh_o = sh_q;
endmodule

// File: rtl/shdw_range_table.sv
module shdw_range_table #(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned N_RANGES = 4,
  localparam int unsigned IDX_W   = $clog2(N_RANGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_start_i,
  input  logic [ADDR_W:0]   cfg_len_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  localparam int unsigned EW = ADDR_W + 2;
  localparam logic [EW-1:0] FULL = {2'b01, {ADDR_W{1'b0}}};

  logic [EW-1:0]     sum, first_end, second_end;
  logic              wrap;
  logic [IDX_W-1:0]  idx2;
  logic [N_RANGES-1:0]   vld_q, hit;
  logic [ADDR_W-1:0] start_q [N_RANGES];
  logic [EW-1:0]     end_q   [N_RANGES];

  assign sum        = {2'b00, cfg_start_i} + {1'b0, cfg_len_i};
  assign wrap       = sum > FULL;
  assign first_end  = wrap ? FULL : sum;
  assign second_end = sum - FULL;
  assign idx2       = (cfg_idx_i == IDX_W'(N_RANGES - 1)) ? '0 : cfg_idx_i + IDX_W'(1);

  for (genvar i = 0; i < N_RANGES; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[i]   <= 1'b0;
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end else if (cfg_we_i) begin
        if (cfg_idx_i == IDX_W'(i)) begin
          vld_q[i]   <= cfg_len_i != '0;
          start_q[i] <= cfg_start_i;
          end_q[i]   <= first_end;
        end else if (wrap && idx2 == IDX_W'(i)) begin
          vld_q[i]   <= 1'b1;
          start_q[i] <= '0;
          end_q[i]   <= second_end;
        end
      end
    end
    assign hit[i] = vld_q[i] && (addr_i >= start_q[i]) && ({2'b00, addr_i} < end_q[i]);
  end

  assign hit_o = |hit;

  assert_wrap_split_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i && wrap |=> end_q[$past(cfg_idx_i)] == FULL && vld_q[$past(idx2)]);
endmodule

// File: rtl/shdw_rule.sv
module shdw_rule
  import shdw_pkg::*;
#(
  parameter int unsigned N_REGS    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned IO_BASE   = 'hFE00,
  parameter int unsigned STACK_REG = 6,
  parameter int unsigned LINK_REG  = 7,
  localparam int unsigned REG_W    = $clog2(N_REGS)
) (
  input  logic              req_valid_i,
  input  logic              strict_i,
  input  cls_e              cls_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic              src_b_en_i,
  input  logic              const_res_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic              base_used_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              fetch_init_i,
  input  logic              mem_init_i,
  input  logic              ptr_init_i,
  input  logic              psr_init_i,
  input  logic              taken_i,
  input  logic              npc_init_i,
  input  logic [N_REGS-1:0] reg_sh_i,
  input  logic              in_range_i,
  output err_e              code_o,
  output logic              reg_we_o,
  output logic [REG_W-1:0]  reg_waddr_o,
  output logic              reg_wdata_o,
  output logic              mem_we_o,
  output logic              mem_val_o
);
  localparam logic [ADDR_W-1:0] IO_LO = ADDR_W'(IO_BASE);

  logic a_ok, b_ok, base_ok, is_io, exempt, is_ld, is_st, is_ldst, is_ind, xfer, alu_val, commit;
  err_e chk;

  always_comb begin
    a_ok    = reg_sh_i[src_a_i];
    b_ok    = src_b_en_i ? reg_sh_i[src_b_i] : 1'b1;
    base_ok = reg_sh_i[base_i];
    is_io   = ea_i >= IO_LO;
    exempt  = (base_used_i && base_i == REG_W'(STACK_REG)) || in_range_i;
    is_ld   = cls_i == CLS_LD || cls_i == CLS_LDI;
    is_st   = cls_i == CLS_ST || cls_i == CLS_STI;
    is_ldst = cls_i == CLS_LD || cls_i == CLS_ST;
    is_ind  = cls_i == CLS_LDI || cls_i == CLS_STI;
    xfer    = (cls_i == CLS_BR && taken_i) || cls_i == CLS_JMP || cls_i == CLS_JSR ||
              cls_i == CLS_JSRR || cls_i == CLS_TRAP || cls_i == CLS_RTI;
    alu_val = const_res_i | (a_ok & b_ok);

    // fixed priority: fetch, address/target, value, next PC
    if (!fetch_init_i)                                          chk = ERR_PC_CUR;
    else if ((is_ldst && base_used_i && !base_ok) || (is_ind && !ptr_init_i))
                                                                chk = ERR_MEM_ADDR;
    else if (cls_i == CLS_JMP && !base_ok)                      chk = ERR_JMP_ADDR;
    else if ((cls_i == CLS_JSRR && !base_ok) || (cls_i == CLS_TRAP && !ptr_init_i))
                                                                chk = ERR_SR_ADDR;
    else if (cls_i == CLS_RTI && !psr_init_i)                   chk = ERR_PSR_SET;
    else if ((cls_i == CLS_ALU && !alu_val) || (is_ld && !mem_init_i && !exempt))
                                                                chk = ERR_REG_SET;
    else if (is_st && !a_ok && is_io)                           chk = ERR_IO_SET;
    else if (is_st && !a_ok && !exempt)                         chk = ERR_MEM_SET;
    else if (xfer && !npc_init_i)                               chk = ERR_PC_NEXT;
    else                                                        chk = ERR_NONE;

    code_o = (req_valid_i && strict_i) ? chk : ERR_NONE;
    commit = req_valid_i && code_o == ERR_NONE;

    reg_we_o    = 1'b0;
    reg_waddr_o = dst_i;
    reg_wdata_o = 1'b0;
    if (cls_i == CLS_ALU) begin
      reg_we_o    = commit;
      reg_wdata_o = alu_val;
    end else if (is_ld) begin
      reg_we_o    = commit;
      reg_wdata_o = mem_init_i;
    end else if (cls_i == CLS_JSR || cls_i == CLS_JSRR || cls_i == CLS_TRAP) begin
      reg_we_o    = commit;
      reg_waddr_o = REG_W'(LINK_REG);
      reg_wdata_o = 1'b1;
    end

    mem_we_o  = commit && is_st && !is_io;
    mem_val_o = a_ok;
  end
endmodule

// File: rtl/shdw_checker.sv
module shdw_checker
  import shdw_pkg::*;
#(
  parameter int unsigned N_REGS    = 8,
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned N_RANGES  = 4,
  parameter int unsigned IO_BASE   = 'hFE00,
  parameter int unsigned STACK_REG = 6,
  parameter int unsigned LINK_REG  = 7,
  parameter logic [N_REGS-1:0] REG_RESET = '0,
  localparam int unsigned REG_W    = $clog2(N_REGS),
  localparam int unsigned IDX_W    = $clog2(N_RANGES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              strict_i,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [ADDR_W-1:0] cfg_start_i,
  input  logic [ADDR_W:0]   cfg_len_i,
  input  logic              req_valid_i,
  input  logic [3:0]        cls_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [REG_W-1:0]  dst_i,
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic              src_b_en_i,
  input  logic              const_res_i,
  input  logic [REG_W-1:0]  base_i,
  input  logic              base_used_i,
  input  logic [ADDR_W-1:0] ea_i,
  input  logic              fetch_init_i,
  input  logic              mem_init_i,
  input  logic              ptr_init_i,
  input  logic              psr_init_i,
  input  logic              taken_i,
  input  logic              npc_init_i,
  output logic              err_valid_o,
  output logic [3:0]        err_code_o,
  output logic [ADDR_W-1:0] err_pc_o,
  output logic              mem_sh_we_o,
  output logic [ADDR_W-1:0] mem_sh_addr_o,
  output logic              mem_sh_val_o,
  output logic [N_REGS-1:0] reg_shadow_o
);
  err_e             code;
  logic             in_range, reg_we, reg_wdata, mem_we, mem_val;
  logic [REG_W-1:0] reg_waddr;
  err_e             code_q;
  logic [ADDR_W-1:0] pc_q, maddr_q;
  logic             mwe_q, mval_q;

  shdw_range_table #(.ADDR_W(ADDR_W), .N_RANGES(N_RANGES)) u_ranges (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_idx_i, .cfg_start_i, .cfg_len_i,
    .addr_i(ea_i), .hit_o(in_range)
  );

  shdw_regfile #(.N_REGS(N_REGS), .RESET_VAL(REG_RESET)) u_regs (
    .clk_i, .rst_ni, .we_i(reg_we), .waddr_i(reg_waddr), .wdata_i(reg_wdata),
    .sh_o(reg_shadow_o)
  );

  shdw_rule #(
    .N_REGS(N_REGS), .ADDR_W(ADDR_W), .IO_BASE(IO_BASE),
    .STACK_REG(STACK_REG), .LINK_REG(LINK_REG)
  ) u_rule (
    .req_valid_i, .strict_i, .cls_i(cls_e'(cls_i)), .dst_i, .src_a_i, .src_b_i,
    .src_b_en_i, .const_res_i, .base_i, .base_used_i, .ea_i, .fetch_init_i,
    .mem_init_i, .ptr_init_i, .psr_init_i, .taken_i, .npc_init_i,
    .reg_sh_i(reg_shadow_o), .in_range_i(in_range), .code_o(code),
    .reg_we_o(reg_we), .reg_waddr_o(reg_waddr), .reg_wdata_o(reg_wdata),
    .mem_we_o(mem_we), .mem_val_o(mem_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q  <= ERR_NONE;
      pc_q    <= '0;
      mwe_q   <= 1'b0;
      maddr_q <= '0;
      mval_q  <= 1'b0;
    end else begin
      code_q  <= code;
      if (code != ERR_NONE) pc_q <= pc_i;
      mwe_q   <= mem_we;
      maddr_q <= ea_i;
      mval_q  <= mem_val;
    end
  end

  assign err_code_o    = code_q;
  assign err_valid_o   = code_q != ERR_NONE;
  assign err_pc_o      = pc_q;
  assign mem_sh_we_o   = mwe_q;
  assign mem_sh_addr_o = maddr_q;
  assign mem_sh_val_o  = mval_q;

  assert_strict_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && !strict_i |=> err_code_o == 4'd0);
  assert_fetch_first_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && strict_i && !fetch_init_i |=> err_code_o == 4'd1);
  assert_br_untaken_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && strict_i && fetch_init_i && cls_i == 4'd6 && !taken_i |=> err_code_o == 4'd0);
  assert_err_pc_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> err_pc_o == $past(pc_i));
  assert_reg_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> reg_shadow_o == $past(reg_shadow_o));
  assert_no_mem_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_valid_o |-> !mem_sh_we_o);
endmodule

// File: tb/shdw_checker_tb.sv
module shdw_checker_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic strict, cfg_we, req_valid, src_b_en, const_res, base_used;
  logic fetch_init, mem_init, ptr_init, psr_init, taken, npc_init;
  logic [1:0]  cfg_idx;
  logic [15:0] cfg_start, pc, ea;
  logic [16:0] cfg_len;
  logic [3:0]  cls;
  logic [2:0]  dst, src_a, src_b, base;
  logic        err_valid, mem_sh_we, mem_sh_val;
  logic [3:0]  err_code;
  logic [15:0] err_pc, mem_sh_addr;
  logic [7:0]  reg_shadow;

  int checks = 0, fails = 0;
  bit done = 0;
  bit [7:0] m_reg;
  bit m_rv[4];
  int unsigned m_rs[4], m_re[4];

  always #(CLK_PERIOD/2) clk = ~clk;

  shdw_checker u_dut (
    .clk_i(clk), .rst_ni(rst_n), .strict_i(strict), .cfg_we_i(cfg_we), .cfg_idx_i(cfg_idx),
    .cfg_start_i(cfg_start), .cfg_len_i(cfg_len), .req_valid_i(req_valid), .cls_i(cls),
    .pc_i(pc), .dst_i(dst), .src_a_i(src_a), .src_b_i(src_b), .src_b_en_i(src_b_en),
    .const_res_i(const_res), .base_i(base), .base_used_i(base_used), .ea_i(ea),
    .fetch_init_i(fetch_init), .mem_init_i(mem_init), .ptr_init_i(ptr_init),
    .psr_init_i(psr_init), .taken_i(taken), .npc_init_i(npc_init),
    .err_valid_o(err_valid), .err_code_o(err_code), .err_pc_o(err_pc),
    .mem_sh_we_o(mem_sh_we), .mem_sh_addr_o(mem_sh_addr), .mem_sh_val_o(mem_sh_val),
    .reg_shadow_o(reg_shadow)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit m_in_range(input int unsigned a);
    for (int i = 0; i < 4; i++)
      if (m_rv[i] && a >= m_rs[i] && a < m_re[i]) return 1;
    return 0;
  endfunction

  function automatic int model_code();
    bit a_ok = m_reg[src_a];
    bit b_ok = src_b_en ? m_reg[src_b] : 1'b1;
    bit bs_ok = m_reg[base];
    bit io = ea >= 16'hFE00;
    bit ex = (base_used && base == 3'd6) || m_in_range(ea);
    if (!req_valid || !strict) return 0;
    if (!fetch_init) return 1;
    case (cls)
      4'd2, 4'd4:  if (base_used && !bs_ok) return 2;
      4'd3, 4'd5:  if (!ptr_init) return 2;
      4'd7:        if (!bs_ok) return 3;
      4'd9:        if (!bs_ok) return 4;
      4'd10:       if (!ptr_init) return 4;
      4'd11:       if (!psr_init) return 5;
      default: ;
    endcase
    case (cls)
      4'd1:       if (!(const_res || (a_ok && b_ok))) return 6;
      4'd2, 4'd3: if (!mem_init && !ex) return 6;
      4'd4, 4'd5: if (!a_ok) begin
                    if (io) return 8;
                    if (!ex) return 7;
                  end
      default: ;
    endcase
    if (((cls == 4'd6 && taken) || cls == 4'd7 || cls == 4'd8 || cls == 4'd9 ||
         cls == 4'd10 || cls == 4'd11) && !npc_init) return 9;
    return 0;
  endfunction

  task automatic model_cfg();
    int unsigned e = int'(cfg_start) + int'(cfg_len);
    if (cfg_len == 0) begin m_rv[cfg_idx] = 0; return; end
    m_rv[cfg_idx] = 1; m_rs[cfg_idx] = cfg_start;
    if (e > 32'h10000) begin
      m_re[cfg_idx] = 32'h10000;
      m_rv[(cfg_idx + 1) % 4] = 1; m_rs[(cfg_idx + 1) % 4] = 0;
      m_re[(cfg_idx + 1) % 4] = e - 32'h10000;
    end else m_re[cfg_idx] = e;
  endtask

  task automatic do_req(input string tag);
    int exp = model_code();
    bit commit = req_valid && exp == 0;
    bit a_ok = m_reg[src_a];
    bit b_ok = src_b_en ? m_reg[src_b] : 1'b1;
    bit mwe = commit && (cls == 4'd4 || cls == 4'd5) && ea < 16'hFE00;
    bit [7:0] nreg = m_reg;
    logic [15:0] pc_s = pc, ea_s = ea;
    if (commit) begin
      if (cls == 4'd1) nreg[dst] = const_res | (a_ok & b_ok);
      else if (cls == 4'd2 || cls == 4'd3) nreg[dst] = mem_init;
      else if (cls == 4'd8 || cls == 4'd9 || cls == 4'd10) nreg[7] = 1'b1;
    end
    if (cfg_we) model_cfg();
    @(negedge clk);
    cfg_we = 0;
    chk({tag, " code"}, err_code, exp);
    chk({tag, " valid"}, err_valid, exp != 0);
    if (exp != 0) chk({tag, " err_pc"}, err_pc, pc_s);
    chk({tag, " mem_we"}, mem_sh_we, mwe);
    if (mwe) begin
      chk({tag, " mem_addr"}, mem_sh_addr, ea_s);
      chk({tag, " mem_val"}, mem_sh_val, a_ok);
    end
    chk({tag, " regs"}, reg_shadow, nreg);
    m_reg = nreg;
  endtask

  task automatic idle();
    strict = 1; cfg_we = 0; cfg_idx = 0; cfg_start = 0; cfg_len = 0;
    req_valid = 1; cls = 4'd0; pc = pc + 16'd1; dst = 0; src_a = 0; src_b = 0;
    src_b_en = 0; const_res = 0; base = 0; base_used = 0; ea = 16'h4000;
    fetch_init = 1; mem_init = 1; ptr_init = 1; psr_init = 1; taken = 0; npc_init = 1;
  endtask

  task automatic req(input string tag, input logic [3:0] c);
    cls = c; do_req(tag); idle();
  endtask

  task automatic cfg(input logic [1:0] i, input logic [15:0] s, input logic [16:0] l);
    req_valid = 0; cfg_we = 1; cfg_idx = i; cfg_start = s; cfg_len = l;
    do_req("R12 cfg"); idle();
  endtask

  function automatic bit rbit(input int pct);
    return $urandom_range(99, 0) < pct;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int unsigned seed_sink;
    seed_sink = $urandom(32'h5EED_0042);
    pc = 16'h3000; idle(); req_valid = 0;
    m_reg = '0;
    for (int i = 0; i < 4; i++) begin m_rv[i] = 0; m_rs[i] = 0; m_re[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R14 reset regs", reg_shadow, 0);
    chk("R14 reset err", err_valid, 0);
    chk("R14 reset mem_we", mem_sh_we, 0);
    idle();

    // R2 / R11: undefined source, then constant results define registers
    dst = 0; src_a = 1; req("R2 alu undef src", 4'd1);
    for (int i = 0; i < 8; i++) if (i != 5) begin dst = 3'(i); const_res = 1; req("R2 alu const", 4'd1); end
    src_a = 5; dst = 2; req("R2 alu undef a", 4'd1);
    src_a = 1; src_b = 5; src_b_en = 1; dst = 2; req("R2 alu undef b", 4'd1);
    src_a = 1; src_b = 2; src_b_en = 1; dst = 3; req("R2 alu ok", 4'd1);
    // R1: strict off propagates undefined into R4
    strict = 0; dst = 4; src_a = 5; req("R1 strict off", 4'd1);
    strict = 0; fetch_init = 0; cls = 4'd7; base = 5; npc_init = 0; req("R1 strict off jmp", 4'd7);
    // R3 loads
    dst = 0; mem_init = 0; req("R3 ld undef", 4'd2);
    dst = 0; mem_init = 0; base_used = 1; base = 6; req("R3 ld R6 exempt", 4'd2);
    dst = 0; const_res = 1; req("R2 redefine", 4'd1);
    dst = 1; mem_init = 0; req("R3 ldi undef", 4'd3);
    // R6 address
    base_used = 1; base = 4; req("R6 ld base undef", 4'd2);
    base_used = 1; base = 4; src_a = 1; req("R6 st base undef", 4'd4);
    ptr_init = 0; req("R6 ldi ptr", 4'd3);
    ptr_init = 0; src_a = 1; req("R6 sti ptr", 4'd5);
    // R4 stores
    src_a = 5; ea = 16'h4000; req("R4 st undef", 4'd4);
    src_a = 5; base_used = 1; base = 6; ea = 16'h4010; req("R4 st R6 exempt", 4'd4);
    src_a = 1; ea = 16'h4020; req("R4 st defined", 4'd4);
    // R5 I/O
    src_a = 5; base_used = 1; base = 6; ea = 16'hFE04; req("R5 io undef", 4'd4);
    src_a = 1; ea = 16'hFFFF; req("R5 io ok no write", 4'd4);
    src_a = 5; ea = 16'hFDFF; base_used = 1; base = 6; req("R5 below io exempt", 4'd4);
    // R7 targets and link
    strict = 0; dst = 7; src_a = 5; req("R7 undefine link", 4'd1);
    base = 4; req("R7 jmp undef", 4'd7);
    base = 4; req("R7 jsrr undef", 4'd9);
    ptr_init = 0; req("R7 trap vec", 4'd10);
    req("R7 jsr defines link", 4'd8);
    // R8 next PC
    taken = 1; npc_init = 0; req("R8 br taken", 4'd6);
    taken = 0; npc_init = 0; req("R8 br untaken", 4'd6);
    base = 1; npc_init = 0; req("R8 jmp next", 4'd7);
    npc_init = 0; req("R8 rti next", 4'd11);
    // R9 / R10 priority
    fetch_init = 0; base = 4; npc_init = 0; req("R9 fetch first", 4'd7);
    psr_init = 0; npc_init = 0; req("R9 rti psr", 4'd11);
    base_used = 1; base = 4; mem_init = 0; req("R10 addr over value", 4'd2);
    src_a = 5; ea = 16'hFE00; ptr_init = 0; req("R10 addr over io", 4'd5);
    ptr_init = 0; npc_init = 0; req("R10 vec over next", 4'd10);
    // R12 ranges
    cfg(2'd0, 16'hFFF0, 17'h20);
    mem_init = 0; ea = 16'h0005; req("R12 wrap low part", 4'd2);
    mem_init = 0; ea = 16'h0010; req("R12 past wrap end", 4'd2);
    mem_init = 0; ea = 16'hFFF8; req("R12 wrap high part", 4'd2);
    src_a = 5; ea = 16'h000F; req("R12 store in range", 4'd4);
    cfg(2'd0, 16'h0, 17'h0); cfg(2'd1, 16'h0, 17'h0);
    mem_init = 0; ea = 16'h0005; req("R12 cleared", 4'd2);
    cfg(2'd2, 16'hFF00, 17'h100);
    mem_init = 0; ea = 16'hFFFF; req("R12 exact end", 4'd2);
    mem_init = 0; ea = 16'hFEFF; req("R12 below start", 4'd2);
    // R13 same-cycle config and request
    cfg_we = 1; cfg_idx = 3; cfg_start = 16'h5000; cfg_len = 17'h10;
    mem_init = 0; ea = 16'h5004; req("R13 add same cycle", 4'd2);
    mem_init = 0; ea = 16'h5004; req("R13 add after", 4'd2);
    cfg_we = 1; cfg_idx = 3; cfg_start = 16'h5000; cfg_len = 17'h0;
    mem_init = 0; ea = 16'h5004; req("R13 clear same cycle", 4'd2);
    mem_init = 0; ea = 16'h5004; req("R13 clear after", 4'd2);

    // constrained random traffic
    for (int n = 0; n < 800; n++) begin
      strict = rbit(85);
      req_valid = rbit(90);
      cls = 4'($urandom_range(11, 0));
      pc = 16'($urandom);
      dst = 3'($urandom); src_a = 3'($urandom); src_b = 3'($urandom); base = 3'($urandom);
      src_b_en = rbit(50); const_res = rbit(30); base_used = rbit(50);
      if (rbit(20)) base = 3'd6;
      fetch_init = rbit(92); mem_init = rbit(60); ptr_init = rbit(85);
      psr_init = rbit(85); taken = rbit(50); npc_init = rbit(85);
      case ($urandom_range(3, 0))
        0: ea = 16'($urandom_range(32'hFFFF, 32'hFDF0));
        1: begin
             int k = $urandom_range(3, 0);
             ea = m_rv[k] ? 16'(m_rs[k] + $urandom_range(3, 0)) : 16'($urandom);
           end
        default: ea = 16'($urandom);
      endcase
      if (rbit(8)) begin
        cfg_we = 1; cfg_idx = 2'($urandom);
        cfg_start = 16'($urandom_range(32'hFFFF, 32'hFF00)) ^ (rbit(50) ? 16'h8000 : 16'h0);
        cfg_len = rbit(15) ? 17'h0 : 17'($urandom_range(300, 1));
      end
      do_req("R10 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule